// File: doc/BRIEF.md
# Receive DMA Buffer Sequencer with Done-Queue Posting

This block is the per-channel steering logic of a receive DMA engine. Bytes arrive one at a time from a receive FIFO. For each byte it decides the host memory address. It draws empty data buffers from a free-buffer pop port, in small or large size according to a configured fill mode. The first buffer of every packet can start a configurable number of bytes past its base.

As buffers fill, the block counts them. It reports the descriptor offset that heads the current chain of buffers to a done queue. That report goes out either after a configured number of filled buffers or when the packet ends. The current write address, the descriptor of the buffer in use and the chain's starting descriptor are all kept in registers.

Illegal settings raise a configuration error and stop all storing. A missing free buffer stalls the FIFO and raises a starvation flag.

Top module: `rx_dma_seq`

## Requirements
- R1: While `cfg_en` is 0, `fifo_ready`, `mw_req`, `fb_pop` and `dq_valid` stay 0 and no byte is consumed.
- R2: With `cfg_mode` = 0, every buffer is requested with `fb_large` = 1 and holds `cfg_large_size` bytes.
- R3: With `cfg_mode` = 1, every buffer is requested with `fb_large` = 0 and holds `cfg_small_size` bytes.
- R4: With `cfg_mode` = 2, the first buffer of a packet is small (`fb_large` = 0) and every later buffer of that packet is large (`fb_large` = 1).
- R5: `cfg_mode` = 3 drives `cfg_err` to 1, and while it is set no byte is written, popped or consumed.
- R6: The first byte of a packet is written at buffer base plus `cfg_offset`, and that buffer counts as filled after size minus offset bytes. Later buffers of the same packet start at their base.
- R7: With `cfg_thresh` = 0, exactly one done-queue entry is posted per packet, after its last byte.
- R8: With `cfg_thresh` = N (1..7), an entry is posted each time N buffers have been filled. The entry carries the descriptor offset of the first buffer of that chain, and the next chain starts at the next buffer popped.
- R9: When the last byte of a packet (`fifo_eop` = 1) is written, any partly posted chain is posted one cycle later, whatever the threshold, and the filled-buffer count restarts at 0.
- R10: `cfg_transparent` = 1 with `cfg_thresh` = 0 drives `cfg_err` to 1 and blocks storing.
- R11: If a buffer is needed while `fb_avail` = 0, `starve` is 1 and `fifo_ready` and `mw_req` stay 0 until a buffer is supplied.
- R12: Within a buffer, each granted byte advances `mw_addr` by one. Without a grant the address and the byte are held.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Channel enable |
| cfg_mode | input | 2 | Buffer fill mode: 0 large, 1 small, 2 small then large, 3 illegal |
| cfg_offset | input | 4 | Byte offset of the first write of a packet |
| cfg_thresh | input | 3 | Filled buffers per done-queue post; 0 = post at end of packet |
| cfg_transparent | input | 1 | Channel runs in transparent mode |
| cfg_small_size | input | 16 | Small buffer size in bytes (must exceed 15) |
| cfg_large_size | input | 16 | Large buffer size in bytes (must exceed 15) |
| fifo_valid | input | 1 | FIFO holds a byte |
| fifo_data | input | 8 | FIFO byte |
| fifo_eop | input | 1 | FIFO byte is the last of its packet |
| fifo_ready | output | 1 | Byte consumed this cycle |
| fb_avail | input | 1 | Free buffer available |
| fb_addr | input | 32 | Base address of the offered free buffer |
| fb_desc | input | 16 | Descriptor offset of the offered free buffer |
| fb_pop | output | 1 | Take the offered free buffer |
| fb_large | output | 1 | Requested buffer is large (1) or small (0) |
| mw_req | output | 1 | Memory byte write request |
| mw_addr | output | 32 | Memory write address |
| mw_data | output | 8 | Memory write byte |
| mw_gnt | input | 1 | Memory write granted |
| dq_valid | output | 1 | One-cycle done-queue post |
| dq_desc | output | 16 | Starting descriptor offset being posted |
| cur_desc | output | 16 | Descriptor offset of the buffer being written |
| cfg_err | output | 1 | Illegal configuration |
| starve | output | 1 | Stalled for lack of a free buffer |

## Verification
A buffer can become full in the same cycle that the packet ends, and the threshold count can also be reached on that same byte. That single byte then closes the buffer, may hit the threshold, and ends the packet. The bench provokes this with packet lengths that end exactly on a buffer edge, with threshold 1 and with mixed-mode offsets. A scoreboard requires exactly one done-queue entry in that case, carrying the chain's starting descriptor. The next packet must then restart with the configured offset in a fresh buffer.

// File: rtl/rx_dma_pkg.sv
package rx_dma_pkg;
    typedef enum logic [1:0] {
        BM_LARGE = 2'd0,
        BM_SMALL = 2'd1,
        BM_MIXED = 2'd2,
        BM_BAD   = 2'd3
    } bufmode_e;
endpackage

// File: rtl/rx_dma_cfg_check.sv
module rx_dma_cfg_check #(
    parameter int TW = 3
) (
    input  logic [1:0]    mode,
    input  logic [TW-1:0] thresh,
    input  logic          transparent,
    output logic          err
);
    import rx_dma_pkg::*;

    always_comb begin
        err = (bufmode_e'(mode) == BM_BAD) || (transparent && (thresh == '0));
    end
endmodule

// File: rtl/rx_dma_buf_pick.sv
module rx_dma_buf_pick #(
    parameter int AW = 32,
    parameter int SW = 16
) (
    input  logic [1:0]    mode,
    input  logic          first_of_pkt,
    input  logic [SW-1:0] small_size,
    input  logic [SW-1:0] large_size,
    output logic          want_large,
    output logic [AW-1:0] size_ext
);
    import rx_dma_pkg::*;

    always_comb begin
        unique case (bufmode_e'(mode))
            BM_LARGE: want_large = 1'b1;
            BM_SMALL: want_large = 1'b0;
            BM_MIXED: want_large = !first_of_pkt;
            default:  want_large = 1'b0;
        endcase
        size_ext = AW'(want_large ? large_size : small_size);
    end
endmodule

// File: rtl/rx_dma_seq.sv
module rx_dma_seq #(
    parameter int AW = 32,
    parameter int DW = 16,
    parameter int SW = 16,
    parameter int OW = 4,
    parameter int TW = 3,
    parameter int BW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [1:0]    cfg_mode,
    input  logic [OW-1:0] cfg_offset,
    input  logic [TW-1:0] cfg_thresh,
    input  logic          cfg_transparent,
    input  logic [SW-1:0] cfg_small_size,
    input  logic [SW-1:0] cfg_large_size,
    input  logic          fifo_valid,
    input  logic [BW-1:0] fifo_data,
    input  logic          fifo_eop,
    output logic          fifo_ready,
    input  logic          fb_avail,
    input  logic [AW-1:0] fb_addr,
    input  logic [DW-1:0] fb_desc,
    output logic          fb_pop,
    output logic          fb_large,
    output logic          mw_req,
    output logic [AW-1:0] mw_addr,
    output logic [BW-1:0] mw_data,
    input  logic          mw_gnt,
    output logic          dq_valid,
    output logic [DW-1:0] dq_desc,
    output logic [DW-1:0] cur_desc,
    output logic          cfg_err,
    output logic          starve
);
    typedef struct packed {
        logic          have_buf;
        logic [AW-1:0] addr;
        logic [AW-1:0] end_addr;
        logic [DW-1:0] cur_desc;
        logic [DW-1:0] start_desc;
        logic          chain_empty;
        logic          first_pkt;
        logic [TW-1:0] cnt;
        logic          dq_valid;
        logic [DW-1:0] dq_desc;
    } seq_state_t;

    seq_state_t q, d;
    logic [AW-1:0] size_ext;
    logic [AW-1:0] addr_nx;
    logic active, need_buf, take, full;

    rx_dma_cfg_check #(.TW(TW)) u_chk (
        .mode        (cfg_mode),
        .thresh      (cfg_thresh),
        .transparent (cfg_transparent),
        .err         (cfg_err)
    );

    rx_dma_buf_pick #(.AW(AW), .SW(SW)) u_pick (
        .mode         (cfg_mode),
        .first_of_pkt (q.first_pkt),
        .small_size   (cfg_small_size),
        .large_size   (cfg_large_size),
        .want_large   (fb_large),
        .size_ext     (size_ext)
    );

    always_comb begin
        active   = cfg_en && !cfg_err;
        need_buf = active && !q.have_buf && fifo_valid;
        fb_pop   = need_buf && fb_avail;
        starve   = need_buf && !fb_avail;
        mw_req   = active && q.have_buf && fifo_valid;
        take     = mw_req && mw_gnt;
        addr_nx  = q.addr + AW'(1);
        full     = (addr_nx == q.end_addr);

        d = q;
        d.dq_valid = 1'b0;
        if (fb_pop) begin
            d.have_buf = 1'b1;
            d.addr     = fb_addr + (q.first_pkt ? AW'(cfg_offset) : '0);
            d.end_addr = fb_addr + size_ext;
            d.cur_desc = fb_desc;
            if (q.chain_empty) begin
                d.start_desc  = fb_desc;
                d.chain_empty = 1'b0;
            end
        end
        if (take) begin
            d.addr = addr_nx;
            if (full || fifo_eop) begin
                d.have_buf = 1'b0;
                if (fifo_eop) begin
                    d.dq_valid    = 1'b1;
                    d.dq_desc     = q.start_desc;
                    d.chain_empty = 1'b1;
                    d.cnt         = '0;
                    d.first_pkt   = 1'b1;
                end else begin
                    d.first_pkt = 1'b0;
                    if ((cfg_thresh != '0) && ((q.cnt + TW'(1)) == cfg_thresh)) begin
                        d.dq_valid    = 1'b1;
                        d.dq_desc     = q.start_desc;
                        d.chain_empty = 1'b1;
                        d.cnt         = '0;
                    end else begin
                        d.cnt = q.cnt + TW'(1);
                    end
                end
            end
        end

        fifo_ready = take;
        mw_addr    = q.addr;
        mw_data    = fifo_data;
        dq_valid   = q.dq_valid;
        dq_desc    = q.dq_desc;
        cur_desc   = q.cur_desc;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            q             <= '0;
            q.chain_empty <= 1'b1;
            q.first_pkt   <= 1'b1;
        end else begin
            q <= d;
        end
    end

    a_r1_off_no_post: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_en |=> !dq_valid);
    a_r5_err_no_store: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |-> (!mw_req && !fb_pop && !fifo_ready));
    a_r9_eop_posts: assert property (@(posedge clk) disable iff (!rst_n)
        (take && fifo_eop) |=> dq_valid);
    a_r11_starve_stall: assert property (@(posedge clk) disable iff (!rst_n)
        starve |-> (!fifo_ready && !mw_req));
    a_r12_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (take && !fifo_eop && !full) |=> (mw_addr == $past(mw_addr) + AW'(1)));
    a_r12_addr_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!take && !fb_pop) |=> $stable(mw_addr));
endmodule

// File: tb/tb_rx_dma_seq.sv
module tb_rx_dma_seq;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_en = 1'b0;
    logic [1:0] cfg_mode = 2'd0;
    logic [3:0] cfg_offset = 4'd0;
    logic [2:0] cfg_thresh = 3'd0;
    logic cfg_transparent = 1'b0;
    logic [15:0] cfg_small_size = 16'd16;
    logic [15:0] cfg_large_size = 16'd32;
    logic fifo_valid = 1'b0;
    logic [7:0] fifo_data = 8'd0;
    logic fifo_eop = 1'b0;
    logic fifo_ready;
    logic fb_avail = 1'b1;
    logic [31:0] fb_addr;
    logic [15:0] fb_desc;
    logic fb_pop, fb_large, mw_req, mw_gnt, dq_valid, cfg_err, starve;
    logic [31:0] mw_addr;
    logic [7:0] mw_data;
    logic [15:0] dq_desc, cur_desc;

    always #2 clk = ~clk;

    rx_dma_seq dut (.*);

    int n_cmp = 0, n_bad = 0;
    int fb_idx = 0;
    int gcnt = 0;
    logic [39:0] exp_wr[$];
    logic [15:0] exp_dq[$];
    logic exp_pop[$];

    int m_idx = 0, m_cnt = 0;
    bit m_have = 0, m_first = 1, m_chain_empty = 1;
    logic [31:0] m_addr, m_end;
    logic [15:0] m_start;

    assign fb_addr = 32'h1000_0000 + 32'(fb_idx) * 32'd256;
    assign fb_desc = 16'(fb_idx + 1);
    always @(posedge clk) if (fb_pop) fb_idx <= fb_idx + 1;
    always @(negedge clk) begin
        gcnt   <= gcnt + 1;
        mw_gnt <= (gcnt % 3) != 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // scoreboard monitor
    always @(negedge clk) begin
        #1;
        if (rst_n) begin
            if (fb_pop) begin
                if (exp_pop.size() == 0) chk(0, "R2/R3/R4 unexpected pop", 1, 0);
                else begin
                    logic e;
                    e = exp_pop.pop_front();
                    chk(fb_large == e, "R2/R3/R4 buffer size", fb_large, e);
                end
            end
            if (mw_req && mw_gnt) begin
                if (exp_wr.size() == 0) chk(0, "R12 unexpected write", mw_addr, 0);
                else begin
                    logic [39:0] w;
                    w = exp_wr.pop_front();
                    chk({mw_addr, mw_data} == w, "R6/R12 write addr+data", {mw_addr, mw_data}, w);
                end
            end
            if (dq_valid) begin
                if (exp_dq.size() == 0) chk(0, "R7/R8/R9 unexpected post", dq_desc, 0);
                else begin
                    logic [15:0] e;
                    e = exp_dq.pop_front();
                    chk(dq_desc == e, "R8/R9 posted descriptor", dq_desc, e);
                end
            end
        end
    end

    task automatic set_cfg(input logic [1:0] mo, input logic [3:0] off, input logic [2:0] th, input bit tr);
        @(negedge clk);
        cfg_mode = mo; cfg_offset = off; cfg_thresh = th; cfg_transparent = tr;
    endtask

    task automatic send_pkt(input int len, input int seed);
        for (int i = 0; i < len; i++) begin
            logic [7:0] b;
            bit lg, last, isfull;
            b = 8'(seed + i);
            last = (i == len - 1);
            if (!m_have) begin
                lg = (cfg_mode == 2'd0) || (cfg_mode == 2'd2 && !m_first);
                exp_pop.push_back(lg);
                m_addr = 32'h1000_0000 + 32'(m_idx) * 32'd256;
                m_end  = m_addr + 32'(lg ? cfg_large_size : cfg_small_size);
                if (m_first) m_addr = m_addr + 32'(cfg_offset);
                if (m_chain_empty) begin m_start = 16'(m_idx + 1); m_chain_empty = 0; end
                m_idx++;
                m_have = 1;
            end
            exp_wr.push_back({m_addr, b});
            m_addr = m_addr + 1;
            isfull = (m_addr == m_end);
            if (isfull || last) begin
                m_have = 0;
                if (last) begin
                    exp_dq.push_back(m_start); m_chain_empty = 1; m_cnt = 0; m_first = 1;
                end else begin
                    m_first = 0;
                    m_cnt++;
                    if (cfg_thresh != 0 && m_cnt == int'(cfg_thresh)) begin
                        exp_dq.push_back(m_start); m_chain_empty = 1; m_cnt = 0;
                    end
                end
            end
            fifo_valid = 1; fifo_data = b; fifo_eop = last;
            forever begin
                #1;
                if (fifo_ready) begin @(negedge clk); break; end
                @(negedge clk);
            end
        end
        fifo_valid = 0; fifo_eop = 0;
        repeat (4) @(negedge clk);
    endtask

    task automatic drain_check(input string req);
        repeat (4) @(negedge clk);
        chk(exp_wr.size() == 0 && exp_dq.size() == 0 && exp_pop.size() == 0, req,
            exp_wr.size() + exp_dq.size() + exp_pop.size(), 0);
    endtask

    initial begin
        #(4 * 150000);
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1;
        @(negedge clk); #1;
        chk(!fifo_ready && !mw_req && !dq_valid && !fb_pop, "reset quiet", {fifo_ready, mw_req, dq_valid}, 0);

        // R1: disabled channel ignores FIFO
        fifo_valid = 1; fifo_data = 8'h55;
        for (int k = 0; k < 5; k++) begin
            @(negedge clk); #1;
            chk(!fifo_ready && !mw_req && !fb_pop && !dq_valid, "R1 disabled", {fifo_ready, mw_req, fb_pop}, 0);
        end
        fifo_valid = 0;
        @(negedge clk);
        cfg_en = 1;

        // R2 + R7: large only, post at end
        set_cfg(2'd0, 4'd0, 3'd0, 0);
        send_pkt(40, 8'h10);
        drain_check("R2 R7 large-only packet");

        // R3 + R6 + R8: small only, offset 3, threshold 2
        set_cfg(2'd1, 4'd3, 3'd2, 0);
        send_pkt(50, 8'h40);
        drain_check("R3 R6 R8 small-only threshold");

        // R4 + R9: mixed, offset 5, threshold 1, packet ends on a buffer edge
        set_cfg(2'd2, 4'd5, 3'd1, 0);
        send_pkt(43, 8'h80);
        send_pkt(60, 8'h90);
        drain_check("R4 R9 mixed with edge end");

        // R9: threshold 3, short packet posts partial chain; counter restarts
        set_cfg(2'd1, 4'd0, 3'd3, 0);
        send_pkt(20, 8'h01);
        send_pkt(48, 8'h21);
        drain_check("R9 partial chain then fresh count");

        // R5: illegal mode
        set_cfg(2'd3, 4'd0, 3'd1, 0);
        fifo_valid = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(cfg_err && !fifo_ready && !mw_req && !fb_pop, "R5 illegal mode", {cfg_err, fifo_ready, mw_req}, 3'b100);
        end
        fifo_valid = 0;

        // R10: transparent with threshold 0
        set_cfg(2'd0, 4'd0, 3'd0, 1);
        fifo_valid = 1;
        for (int k = 0; k < 3; k++) begin
            @(negedge clk); #1;
            chk(cfg_err && !fifo_ready && !mw_req, "R10 transparent thresh 0", {cfg_err, fifo_ready, mw_req}, 3'b100);
        end
        fifo_valid = 0;
        set_cfg(2'd0, 4'd0, 3'd2, 1);
        @(negedge clk); #1;
        chk(!cfg_err, "R10 transparent thresh 2 legal", cfg_err, 0);

        // R11: starvation
        set_cfg(2'd1, 4'd0, 3'd0, 0);
        fb_avail = 0;
        fork
            send_pkt(20, 8'hC0);
            begin
                repeat (3) @(negedge clk);
                #1;
                chk(starve && !fifo_ready && !mw_req, "R11 starvation stall", {starve, fifo_ready, mw_req}, 3'b100);
                @(negedge clk);
                fb_avail = 1;
            end
        join
        drain_check("R11 recovery after starvation");
        #1;
        chk(!starve, "R11 starve cleared", starve, 0);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule